// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes frequency-synthesizer settings over a three-wire serial link: a data line, a serial clock and a load strobe. Each bit on the data line enters a 19-bit shift register on a rising clock edge, with the most significant bit sent first. The load strobe is sampled in the serial clock domain. When it goes high, the register contents are copied into one of two holding registers. The last bit shifted in selects which one.

The reference holding register keeps a 14-bit reference division ratio and three single-bit controls: the prescaler modulus select, the phase comparator polarity and the monitor output select. The main holding register keeps a 7-bit swallow count and an 11-bit main count. Each holding register raises a one-cycle update pulse when it is written. A sticky error flag marks any latched setting the divider chain cannot use. Words can be loaded at any time, including while the rest of the synthesizer is powered down.

Top module: `synth_prog_if`

## Requirements
- R1: One data bit is shifted in on each rising serial clock edge while the load strobe is low, most significant bit first. The last bit shifted in occupies frame position 1, which is register bit 0.
- R2: On a load, if the frame position 1 bit is 1 the word goes to the reference register, and if it is 0 the word goes to the main register. The register that is not selected keeps its value.
- R3: Reference frame fields: the ratio is in positions 2..15 (position 2 is the LSB), prescaler select is in position 16, phase polarity in position 17 and monitor select in position 18.
- R4: Main frame fields: the swallow count is in positions 2..8 and the main count is in positions 9..19. The LSB of each field is at the lower position.
- R5: A transfer happens only on the clock edge where the load strobe is first seen high. If the strobe stays high for more cycles, no further transfer takes place.
- R6: Each update flag is high for exactly one cycle after its register is written, with the new value already present on the outputs.
- R7: Reset clears both holding registers, both update flags and the error flag to zero.
- R8: The error flag goes high after a reference load whose ratio is below 5. The loaded value is still latched.
- R9: The error flag goes high after a main load whose main count is below 5, or whose swallow count is not less than the main count. The loaded values are still latched.
- R10: Once the error flag is set, it stays high until reset. Loads with legal values do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data is shifted in on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_le | input | 1 | Load strobe, active high |
| ref_ratio | output | 14 | Latched reference division ratio |
| pre_sel | output | 1 | Latched prescaler modulus select |
| phase_pol | output | 1 | Latched phase comparator polarity |
| mon_sel | output | 1 | Latched monitor output select |
| swallow_cnt | output | 7 | Latched swallow count |
| main_cnt | output | 11 | Latched main count |
| ref_upd | output | 1 | One-cycle pulse after a reference register write |
| main_upd | output | 1 | One-cycle pulse after a main register write |
| cfg_err | output | 1 | Sticky flag for an illegal latched setting |

## Verification
A transfer and the error check happen on the same edge. The error decision is made on the word that is being latched at that edge, not on the old contents of the holding register. The bench provokes this by sweeping main counts and swallow counts across the legal boundary, with a reset before each load. After every load it checks the latched fields and the error flag together, in the same cycle as the update pulse. It also holds the strobe high for an extra cycle to confirm that no second pulse or error change follows.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  // A ratio is illegal when it is below the divider's minimum count.
  function automatic logic ratio_low(input int unsigned value, input int unsigned min_val);
    return value < min_val;
  endfunction

  // Pulse swallowing needs the swallow count to be strictly less than the main count.
  function automatic logic swallow_over(input int unsigned swal, input int unsigned main);
    return swal >= main;
  endfunction

endpackage

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_data,
  input  logic            ser_le,
  output logic [SR_W-1:0] word,
  output logic            le_rise
);
  logic le_q;

  assign le_rise = ser_le & ~le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      le_q <= 1'b0;
    end else begin
      le_q <= ser_le;
      if (!ser_le) word <= {word[SR_W-2:0], ser_data};
    end
  end
endmodule

// File: rtl/sp_ref_latch.sv
module sp_ref_latch #(
  parameter int REF_W = 14,
  parameter int SR_W  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SR_W-1:0]  word,
  output logic [REF_W-1:0] ratio,
  output logic             pre_sel,
  output logic             phase_pol,
  output logic             mon_sel,
  output logic             upd
);
  localparam int PRE_POS = REF_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio     <= '0;
      pre_sel   <= 1'b0;
      phase_pol <= 1'b0;
      mon_sel   <= 1'b0;
      upd       <= 1'b0;
    end else begin
      upd <= load;
      if (load) begin
        ratio     <= word[REF_W:1];
        pre_sel   <= word[PRE_POS];
        phase_pol <= word[PRE_POS+1];
        mon_sel   <= word[PRE_POS+2];
      end
    end
  end
endmodule

// File: rtl/sp_main_latch.sv
module sp_main_latch #(
  parameter int SWAL_W = 7,
  parameter int MAIN_W = 11,
  parameter int SR_W   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SR_W-1:0]   word,
  output logic [SWAL_W-1:0] swal,
  output logic [MAIN_W-1:0] main,
  output logic              upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swal <= '0;
      main <= '0;
      upd  <= 1'b0;
    end else begin
      upd <= load;
      if (load) begin
        swal <= word[SWAL_W:1];
        main <= word[SR_W-1:SWAL_W+1];
      end
    end
  end
endmodule

// File: rtl/sp_err.sv
module sp_err #(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_load,
  input  logic [REF_W-1:0]  ref_in,
  input  logic              main_load,
  input  logic [SWAL_W-1:0] swal_in,
  input  logic [MAIN_W-1:0] main_in,
  output logic              err
);
  import synth_prog_pkg::*;

  logic ref_bad, main_bad;

  assign ref_bad  = ref_load & ratio_low(int'(ref_in), MIN_DIV);
  assign main_bad = main_load & (ratio_low(int'(main_in), MIN_DIV) |
                                 swallow_over(int'(swal_in), int'(main_in)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else if (ref_bad || main_bad) err <= 1'b1;
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              pre_sel,
  output logic              phase_pol,
  output logic              mon_sel,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              ref_upd,
  output logic              main_upd,
  output logic              cfg_err
);
  localparam int SR_W = 1 + SWAL_W + MAIN_W;

  logic [SR_W-1:0] word;
  logic            le_rise;
  logic            route_bit;
  logic            ref_load, main_load;

  assign route_bit = word[0];
  assign ref_load  = le_rise & route_bit;
  assign main_load = le_rise & ~route_bit;

  sp_shift #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_le(ser_le),
    .word(word), .le_rise(le_rise)
  );

  sp_ref_latch #(.REF_W(REF_W), .SR_W(SR_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .load(ref_load), .word(word),
    .ratio(ref_ratio), .pre_sel(pre_sel), .phase_pol(phase_pol),
    .mon_sel(mon_sel), .upd(ref_upd)
  );

  sp_main_latch #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .SR_W(SR_W)) u_main (
    .clk(clk), .rst_n(rst_n), .load(main_load), .word(word),
    .swal(swallow_cnt), .main(main_cnt), .upd(main_upd)
  );

  sp_err #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .MIN_DIV(MIN_DIV)) u_err (
    .clk(clk), .rst_n(rst_n),
    .ref_load(ref_load), .ref_in(word[REF_W:1]),
    .main_load(main_load), .swal_in(word[SWAL_W:1]), .main_in(word[SR_W-1:SWAL_W+1]),
    .err(cfg_err)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int REF_W  = 14,
  parameter int SWAL_W = 7,
  parameter int MAIN_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              le_rise,
  input logic              route_bit,
  input logic [REF_W-1:0]  ref_ratio,
  input logic [SWAL_W-1:0] swallow_cnt,
  input logic [MAIN_W-1:0] main_cnt,
  input logic              ref_upd,
  input logic              main_upd,
  input logic              cfg_err
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) !(ref_upd && main_upd)); // R2
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ref_upd |-> $stable(ref_ratio)); // R2
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !main_upd |-> ($stable(main_cnt) && $stable(swallow_cnt))); // R2
  AST_REF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ref_upd) |-> $past(le_rise && route_bit)); // R5
  AST_MAIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(main_upd) |-> $past(le_rise && !route_bit)); // R5
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ref_upd |=> !ref_upd); // R6
  AST_MAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) main_upd |=> !main_upd); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R10
  AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_err) |-> (ref_upd || main_upd)); // R8
endmodule

bind synth_prog_if synth_prog_if_chk #(.REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .route_bit(route_bit),
  .ref_ratio(ref_ratio), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
  .ref_upd(ref_upd), .main_upd(main_upd), .cfg_err(cfg_err)
);

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic pre_sel, phase_pol, mon_sel;
  logic [6:0] swallow_cnt;
  logic [10:0] main_cnt;
  logic ref_upd, main_upd, cfg_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  synth_prog_if uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .pre_sel(pre_sel), .phase_pol(phase_pol), .mon_sel(mon_sel),
    .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
    .ref_upd(ref_upd), .main_upd(main_upd), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ser_le = 1'b0; ser_data = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Shift the whole 19-bit frame MSB first, raise the strobe, and return at the
  // negedge after the transfer edge, where the update pulse is visible.
  task automatic send(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) begin
      @(negedge clk);
      ser_data = w[i];
    end
    @(negedge clk);
    ser_le = 1'b1;
    ser_data = 1'b0;
    @(negedge clk);
  endtask

  // Drop the strobe after one extra high cycle and check that no second pulse appears.
  task automatic finish_load();
    @(negedge clk);
    chk("R5 no repeat ref pulse", int'(ref_upd), 0);
    chk("R5 no repeat main pulse", int'(main_upd), 0);
    ser_le = 1'b0;
  endtask

  function automatic logic [18:0] ref_word(input int r, input bit p, input bit f, input bit m);
    return 19'((m << 17) | (f << 16) | (p << 15) | (r << 1) | 1);
  endfunction

  function automatic logic [18:0] main_word(input int a, input int n);
    return 19'((n << 8) | (a << 1));
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R7 reset state
    chk("R7 ref_ratio", int'(ref_ratio), 0);
    chk("R7 main_cnt", int'(main_cnt), 0);
    chk("R7 swallow", int'(swallow_cnt), 0);
    chk("R7 ref_upd", int'(ref_upd), 0);
    chk("R7 main_upd", int'(main_upd), 0);
    chk("R7 cfg_err", int'(cfg_err), 0);

    // R1 R3 R6: reference loads with walking control bits and varied ratios
    for (int k = 0; k < 8; k++) begin
      int r;
      r = (k == 7) ? 16383 : 5 + k * 2311;
      send(ref_word(r, k[0], k[1], k[2]));
      chk("R3 ratio", int'(ref_ratio), r);
      chk("R3 pre_sel", int'(pre_sel), int'(k[0]));
      chk("R3 phase_pol", int'(phase_pol), int'(k[1]));
      chk("R3 mon_sel", int'(mon_sel), int'(k[2]));
      chk("R6 ref pulse", int'(ref_upd), 1);
      chk("R2 main untouched pulse", int'(main_upd), 0);
      chk("R2 main untouched value", int'(main_cnt), 0);
      chk("R10 legal ref no err", int'(cfg_err), 0);
      finish_load();
    end

    // R4 R2: main load leaves the reference register alone
    send(main_word(100, 2047));
    chk("R4 swallow", int'(swallow_cnt), 100);
    chk("R4 main", int'(main_cnt), 2047);
    chk("R6 main pulse", int'(main_upd), 1);
    chk("R2 ref untouched", int'(ref_ratio), 16383);
    chk("R2 ref no pulse", int'(ref_upd), 0);
    finish_load();

    // R8: reference ratio sweep over the low boundary
    for (int r = 0; r < 10; r++) begin
      do_reset();
      send(ref_word(r, 1'b0, 1'b0, 1'b0));
      chk("R8 latched ratio", int'(ref_ratio), r);
      chk("R8 ref err", int'(cfg_err), (r < 5) ? 1 : 0);
      finish_load();
    end

    // R9: main/swallow sweep around both limits
    for (int n = 0; n < 10; n++) begin
      for (int a = 0; a < 10; a++) begin
        do_reset();
        send(main_word(a, n));
        chk("R9 latched main", int'(main_cnt), n);
        chk("R9 latched swallow", int'(swallow_cnt), a);
        chk("R9 main err", int'(cfg_err), (n < 5 || a >= n) ? 1 : 0);
        finish_load();
      end
    end

    // R10: sticky after a bad load, despite a following legal load
    do_reset();
    send(ref_word(2, 1'b0, 1'b0, 1'b0));
    finish_load();
    send(main_word(3, 500));
    chk("R10 sticky err", int'(cfg_err), 1);
    chk("R10 main still latched", int'(main_cnt), 500);
    finish_load();

    // R1: strobe held long; shifting resumes only after it drops, MSB first
    send(main_word(127, 1));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 long strobe no pulse", int'(main_upd), 0);
    end
    ser_le = 1'b0;
    send(main_word(1, 1024));
    chk("R1 msb first main", int'(main_cnt), 1024);
    chk("R1 swallow lsb", int'(swallow_cnt), 1);
    finish_load();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule